// File: doc/BRIEF.md
# Set-on-Match Clear-on-Overflow PWM Channel

This block is one 16-bit pulse-width channel paired with a free-running timebase counter. The counter advances by one on every cycle where the timebase tick input is high, and wraps from all-ones to zero. A compare value sets the point in each period where the output turns on. When the counter reaches the compare value the output goes high. When the counter wraps the output goes low. The output is therefore high for (2^CNT_W − compare) of the 2^CNT_W ticks in a period.

Software reaches the channel through a byte-wide write port and a combinational read port. There are four registers: a mode byte, the low and high halves of the compare value, and a flag byte. A write to the compare low half switches the comparator off. A write to the high half switches it back on, so a two-byte update never matches against a half-written value. Turning the comparator off gives a true 0% output. Two sticky flags are provided. One records a compare match, which is the rising edge of the output. The other records a counter wrap, which is the falling edge. A level interrupt request follows the match flag when the interrupt enable is set.

Top module: `spwm_channel`

## Requirements
- R1: After synchronous reset the count is 0, the output and the interrupt request are low, and all four registers read 0.
- R2: On each clock where tick is 1 the count increases by one, wrapping from 2^CNT_W−1 to 0. On a clock where tick is 0 it holds.
- R3: The channel runs only when mode bit 1 (PWM select) and mode bit 2 (wide select) are both 1. On the clock edge after an edge where either bit is 0, the output is 0.
- R4: With mode bits 0, 1 and 2 set, the output rises on the tick that brings the count to the compare value. In the cycle after that edge, the count equals the compare value.
- R5: The output falls on the tick that wraps the count to 0. If the compare value is 0, the match at that same tick wins and the output stays high.
- R6: In steady operation, exactly 2^CNT_W − C of the 2^CNT_W cycles in a period are high, where C is the compare value. The output is high exactly while the count is ≥ C.
- R7: A write to address 1 loads compare bits [7:0] and clears mode bit 0 (comparator enable). A write to address 2 loads compare bits [CNT_W−1:8] from the low data bits and sets mode bit 0. Address 0 is the mode byte: bit 0 enable, bit 1 PWM select, bit 2 wide select, bit 3 match-flag enable, bit 4 interrupt enable.
- R8: While mode bit 0 is 0, no match occurs. From the next wrap on, the output stays low for whole periods (0% duty).
- R9: Flag bit 0 (address 3) is set on each compare match when mode bit 3 is 1. It is not set when mode bit 3 is 0.
- R10: Flag bit 1 (address 3) is set on every counter wrap.
- R11: The flags are sticky. A write to address 3 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A hardware set on the same edge wins over the clear.
- R12: irq_o is high exactly while flag bit 0 and mode bit 4 are both 1.
- R13: A new compare value is used from the first tick after the high-byte write, within the current period. It is not held back until the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase advance enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 mode, 1 compare low, 2 compare high, 3 flags |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 8 | Combinational read data |
| count_o | output | CNT_W | Timebase count |
| pwm_o | output | 1 | Pulse-width output |
| irq_o | output | 1 | Interrupt request (level) |

## Verification
The hardest case to reach from the ports is a software flag clear that lands on the same clock edge as a hardware flag set. The bench keeps tick high so the count is known in every cycle. It starts the flag-clear write in the cycle where the count is at its maximum, so the store edge is also the wrap edge. It then reads back a kept overflow flag and a cleared match flag. A second timing-critical case is a compare change in the middle of a period. That low/high write pair is placed a fixed number of counts before the new compare value, so the rise can be checked in the same period.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 2'd0,
        REG_CMP_LO = 2'd1,
        REG_CMP_HI = 2'd2,
        REG_FLAGS  = 2'd3
    } reg_addr_e;

    // Packed so that bit 0 is the comparator enable, bit 4 the interrupt enable.
    typedef struct packed {
        logic irq_en;
        logic flag_en;
        logic wide_sel;
        logic pwm_sel;
        logic cmp_en;
    } mode_t;

    localparam int unsigned MODE_W = $bits(mode_t);

    // Bit 0 match, bit 1 overflow.
    typedef struct packed {
        logic ovf;
        logic match;
    } flags_t;

    localparam int unsigned FLAGS_W = $bits(flags_t);

    typedef enum logic [1:0] {
        OUT_HOLD,
        OUT_SET,
        OUT_CLR,
        OUT_KILL
    } out_act_e;

    function automatic mode_t mode_from_byte(input logic [BYTE_W-1:0] b);
        return mode_t'(b[MODE_W-1:0]);
    endfunction

    function automatic logic [BYTE_W-1:0] mode_to_byte(input mode_t m);
        logic [BYTE_W-1:0] r;
        r = '0;
        r[MODE_W-1:0] = m;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] flags_to_byte(input flags_t f);
        logic [BYTE_W-1:0] r;
        r = '0;
        r[FLAGS_W-1:0] = f;
        return r;
    endfunction

    // Software clear first, then hardware set, so a same-edge event wins.
    function automatic flags_t flags_next(
        input flags_t               cur,
        input logic                 sw_wr,
        input logic [FLAGS_W-1:0]   sw_keep,
        input logic                 hw_match,
        input logic                 hw_ovf
    );
        flags_t n;
        n = cur;
        if (sw_wr) begin
            n.match = n.match & sw_keep[0];
            n.ovf   = n.ovf   & sw_keep[1];
        end
        if (hw_match) n.match = 1'b1;
        if (hw_ovf)   n.ovf   = 1'b1;
        return n;
    endfunction

    // Mode gating first, then set beats clear.
    function automatic out_act_e pick_action(
        input logic mode_ok,
        input logic match,
        input logic wrap
    );
        if (!mode_ok)   return OUT_KILL;
        else if (match) return OUT_SET;
        else if (wrap)  return OUT_CLR;
        else            return OUT_HOLD;
    endfunction

endpackage

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Value the counter takes on a tick edge.
    assign cnt_next_o = cnt_q + 1'b1;
    assign wrap_o     = tick_i && (cnt_q == CNT_MAX);
    assign cnt_o      = cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_next_o;
        end
    end

endmodule

// File: rtl/spwm_regfile.sv
module spwm_regfile
    import spwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [BYTE_W-1:0]   rd_data_o,
    input  logic                hw_match_i,
    input  logic                hw_ovf_i,
    output mode_t               mode_o,
    output logic [CNT_W-1:0]    cmp_o,
    output flags_t              flags_o
);

    localparam int unsigned HI_W = CNT_W - BYTE_W;

    initial begin
        if (CNT_W <= BYTE_W || CNT_W > 2 * BYTE_W) begin
            $error("spwm_regfile: CNT_W must lie in 9..16");
        end
    end

    mode_t            mode_q,  mode_d;
    logic [CNT_W-1:0] cmp_q,   cmp_d;
    flags_t           flags_q, flags_d;
    reg_addr_e        wsel;
    reg_addr_e        rsel;
    logic [BYTE_W-1:0] hi_byte;

    assign wsel = reg_addr_e'(wr_addr_i);
    assign rsel = reg_addr_e'(rd_addr_i);

    // Mode and compare next state, including enable side effects of the byte writes.
    always_comb begin
        mode_d = mode_q;
        cmp_d  = cmp_q;
        if (wr_en_i) begin
            unique case (wsel)
                REG_MODE: begin
                    mode_d = mode_from_byte(wr_data_i);
                end
                REG_CMP_LO: begin
                    cmp_d[BYTE_W-1:0] = wr_data_i;
                    mode_d.cmp_en     = 1'b0;
                end
                REG_CMP_HI: begin
                    cmp_d[CNT_W-1:BYTE_W] = wr_data_i[HI_W-1:0];
                    mode_d.cmp_en         = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        flags_d = flags_next(flags_q,
                             wr_en_i && (wsel == REG_FLAGS),
                             wr_data_i[FLAGS_W-1:0],
                             hw_match_i,
                             hw_ovf_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q  <= '0;
            cmp_q   <= '0;
            flags_q <= '0;
        end else begin
            mode_q  <= mode_d;
            cmp_q   <= cmp_d;
            flags_q <= flags_d;
        end
    end

    always_comb begin
        hi_byte = '0;
        hi_byte[HI_W-1:0] = cmp_q[CNT_W-1:BYTE_W];
    end

    always_comb begin
        unique case (rsel)
            REG_MODE:   rd_data_o = mode_to_byte(mode_q);
            REG_CMP_LO: rd_data_o = cmp_q[BYTE_W-1:0];
            REG_CMP_HI: rd_data_o = hi_byte;
            REG_FLAGS:  rd_data_o = flags_to_byte(flags_q);
            default:    rd_data_o = '0;
        endcase
    end

    assign mode_o  = mode_q;
    assign cmp_o   = cmp_q;
    assign flags_o = flags_q;

endmodule

// File: rtl/spwm_outstage.sv
module spwm_outstage
    import spwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  mode_t            mode_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic             wrap_i,
    output logic             match_o,
    output logic             pwm_o
);

    logic     mode_ok;
    logic     out_q, out_d;
    out_act_e act;

    // Both mode-select bits are needed for this channel mode.
    assign mode_ok = mode_i.pwm_sel && mode_i.wide_sel;

    // The match is taken on the count the tick is about to load, so the
    // output turns on in the same cycle the counter shows the compare value.
    assign match_o = tick_i && mode_ok && mode_i.cmp_en && (cnt_next_i == cmp_i);

    assign act = pick_action(mode_ok, match_o, wrap_i);

    always_comb begin
        unique case (act)
            OUT_SET:  out_d = 1'b1;
            OUT_CLR:  out_d = 1'b0;
            OUT_KILL: out_d = 1'b0;
            default:  out_d = out_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pwm_o = out_q;

endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
    import spwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [7:0]       rd_data_o,
    output logic [CNT_W-1:0] count_o,
    output logic             pwm_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_next;
    logic             wrap;
    logic             match_evt;
    mode_t            mode_q;
    logic [CNT_W-1:0] cmp_q;
    flags_t           flags_q;

    spwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick_i),
        .cnt_o      (count_o),
        .cnt_next_o (cnt_next),
        .wrap_o     (wrap)
    );

    spwm_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .hw_match_i (match_evt && mode_q.flag_en),
        .hw_ovf_i   (wrap),
        .mode_o     (mode_q),
        .cmp_o      (cmp_q),
        .flags_o    (flags_q)
    );

    spwm_outstage #(.CNT_W(CNT_W)) u_out (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick_i),
        .mode_i     (mode_q),
        .cmp_i      (cmp_q),
        .cnt_next_i (cnt_next),
        .wrap_i     (wrap),
        .match_o    (match_evt),
        .pwm_o      (pwm_o)
    );

    assign irq_o = flags_q.match && mode_q.irq_en;

endmodule

// File: rtl/spwm_channel_chk.sv
module spwm_channel_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             wr_d0,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp,
    input logic             cmp_en,
    input logic             pwm_sel,
    input logic             wide_sel,
    input logic             flag_en,
    input logic             pwm,
    input logic             match_flag,
    input logic             ovf_flag
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_plus;
    logic             run_ok;

    assign count_plus = count + 1'b1;
    assign run_ok     = pwm_sel && wide_sel;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count == $past(count_plus)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    assert_mode_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !run_ok |=> !pwm);

    assert_rise_at_cmp_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm) |-> ((count == $past(cmp)) && $past(cmp_en)));

    assert_fall_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm) |-> ((count == '0) || !$past(run_ok)));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && (count == TOP) && (cmp == '0) && cmp_en && run_ok) |=> pwm);

    assert_lo_disables_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 2'd1)) |=> !cmp_en);

    assert_hi_enables_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 2'd2)) |=> cmp_en);

    assert_match_flag_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwm) && $past(flag_en)) |-> match_flag);

    assert_ovf_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && (count == TOP)) |=> ovf_flag);

    assert_sticky_match_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(match_flag) |-> $past(wr_en && (wr_addr == 2'd3) && !wr_d0));

endmodule

bind spwm_channel spwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk_i),
    .rst        (rst_i),
    .tick       (tick_i),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_d0      (wr_data_i[0]),
    .count      (count_o),
    .cmp        (cmp_q),
    .cmp_en     (mode_q.cmp_en),
    .pwm_sel    (mode_q.pwm_sel),
    .wide_sel   (mode_q.wide_sel),
    .flag_en    (mode_q.flag_en),
    .pwm        (pwm_o),
    .match_flag (flags_q.match),
    .ovf_flag   (flags_q.ovf)
);

// File: tb/spwm_channel_bench.sv
`timescale 1ns/1ps
module spwm_channel_bench;

    localparam int W      = 9;
    localparam int PERIOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic [W-1:0] count;
    logic         pwm;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spwm_channel #(.CNT_W(W)) u_spwm_channel (
        .clk_i     (clk),
        .rst_i     (rst),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .count_o   (count),
        .pwm_o     (pwm),
        .irq_o     (irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic set_cmp(input int v);
        wr(2'd1, 8'(v & 8'hFF));
        wr(2'd2, 8'((v >> 8) & 8'hFF));
    endtask

    task automatic wait_count(input int v);
        while (int'(count) != v) @(negedge clk);
    endtask

    // One full period from a wrap: high-cycle total and shape mismatches.
    task automatic measure(input int cmpv, output int high, output int mism);
        high = 0; mism = 0;
        wait_count(0);
        for (int i = 0; i < PERIOD; i++) begin
            high += int'(pwm);
            if (pwm != (int'(count) >= cmpv)) mism++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int v, hi, mm, exp_cnt, bad;
        int sweep [20] = '{0, 1, 2, 3, 37, 100, 127, 128, 200, 254,
                           255, 256, 257, 300, 383, 384, 450, 509, 510, 511};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(count == 0, "R1", "count", int'(count), 0);
        check(pwm == 1'b0, "R1", "pwm", int'(pwm), 0);
        check(irq == 1'b0, "R1", "irq", int'(irq), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R1", $sformatf("reg%0d", a), v, 0);
        end

        // R2: irregular tick pattern, then wrap
        exp_cnt = 0; bad = 0;
        for (int i = 0; i < 40; i++) begin
            tick = ((i % 3) != 0);
            exp_cnt = (exp_cnt + int'(tick)) % PERIOD;
            @(negedge clk);
            if (int'(count) != exp_cnt) bad++;
        end
        check(bad == 0, "R2", "tick pattern mismatches", bad, 0);
        tick = 1'b1;
        wait_count(PERIOD - 1);
        @(negedge clk);
        check(count == 0, "R2", "wrap to zero", int'(count), 0);

        // R7: byte writes gate the enable
        wr(2'd0, 8'h06);
        set_cmp(9'h1A5);
        rd(2'd0, v);
        check((v & 1) == 1, "R7", "enable after high write", v & 1, 1);
        rd(2'd1, v);
        check(v == 8'hA5, "R7", "compare low byte", v, 8'hA5);
        rd(2'd2, v);
        check(v == 1, "R7", "compare high byte", v, 1);
        wr(2'd1, 8'h10);
        rd(2'd0, v);
        check((v & 1) == 0, "R7", "enable after low write", v & 1, 0);

        // R8: comparator off gives whole periods at 0%
        wr(2'd0, 8'h0E);
        wr(2'd3, 8'h00);
        measure(PERIOD, hi, mm);
        check(hi == 0, "R8", "high cycles with enable off", hi, 0);
        rd(2'd3, v);
        check((v & 1) == 0, "R8", "no match flag with enable off", v & 1, 0);

        // R4 R5 R6 R9 R10: sweep of compare values
        foreach (sweep[k]) begin
            wr(2'd0, 8'h0E);
            set_cmp(sweep[k]);
            wr(2'd3, 8'h00);
            measure(sweep[k], hi, mm);
            check(hi == PERIOD - sweep[k], "R6",
                  $sformatf("high cycles cmp=%0d", sweep[k]), hi, PERIOD - sweep[k]);
            check(mm == 0, "R4",
                  $sformatf("edge placement cmp=%0d", sweep[k]), mm, 0);
            rd(2'd3, v);
            check((v & 1) == 1, "R9", $sformatf("match flag cmp=%0d", sweep[k]), v & 1, 1);
            check((v & 2) == 2, "R10", $sformatf("overflow flag cmp=%0d", sweep[k]), v & 2, 2);
        end

        // R5: compare 0 holds high across the wrap
        wr(2'd0, 8'h0E);
        set_cmp(0);
        wait_count(PERIOD - 1);
        @(negedge clk);
        check(pwm == 1'b1, "R5", "set wins at wrap with cmp 0", int'(pwm), 1);
        set_cmp(50);
        wait_count(PERIOD - 1);
        @(negedge clk);
        check(pwm == 1'b0, "R5", "fall at wrap with cmp 50", int'(pwm), 0);

        // R9: match flag not set without its enable
        wr(2'd0, 8'h06);
        set_cmp(50);
        wr(2'd3, 8'h00);
        measure(50, hi, mm);
        rd(2'd3, v);
        check((v & 1) == 0, "R9", "match flag with enable off", v & 1, 0);
        check(hi == PERIOD - 50, "R6", "high cycles without flag enable", hi, PERIOD - 50);

        // R3: wide select cleared -> no output
        set_cmp(100);
        wr(2'd0, 8'h0B);
        measure(PERIOD, hi, mm);
        check(hi == 0, "R3", "high cycles with wide select off", hi, 0);
        // R3: PWM select dropped while high
        wr(2'd0, 8'h0E);
        set_cmp(100);
        wait_count(300);
        check(pwm == 1'b1, "R3", "high before mode change", int'(pwm), 1);
        wr(2'd0, 8'h0D);
        @(negedge clk);
        check(pwm == 1'b0, "R3", "low after mode change", int'(pwm), 0);

        // R13: compare change inside a period
        wr(2'd0, 8'h0E);
        set_cmp(400);
        wait_count(98);
        set_cmp(200);
        wait_count(199);
        check(pwm == 1'b0, "R13", "low before new compare", int'(pwm), 0);
        @(negedge clk);
        check(pwm == 1'b1, "R13", "high at new compare", int'(pwm), 1);

        // R12: interrupt follows flag and enable
        wr(2'd0, 8'h1E);
        set_cmp(60);
        wr(2'd3, 8'h00);
        measure(60, hi, mm);
        check(irq == 1'b1, "R12", "irq with flag and enable", int'(irq), 1);
        wr(2'd0, 8'h0F);
        check(irq == 1'b0, "R12", "irq with enable off", int'(irq), 0);
        wr(2'd0, 8'h1F);
        check(irq == 1'b1, "R12", "irq re-enabled", int'(irq), 1);

        // R11: sticky flags, per-bit clear, tick halted
        tick = 1'b0;
        wr(2'd3, 8'h02);
        rd(2'd3, v);
        check(v == 2, "R11", "clear match keep overflow", v, 2);
        check(irq == 1'b0, "R12", "irq after flag clear", int'(irq), 0);
        wr(2'd3, 8'h01);
        rd(2'd3, v);
        check(v == 0, "R11", "clear overflow", v, 0);
        repeat (5) @(negedge clk);
        rd(2'd3, v);
        check(v == 0, "R11", "flags stay clear", v, 0);

        // R11: clear on the same edge as the wrap
        tick = 1'b1;
        wr(2'd0, 8'h0E);
        set_cmp(100);
        wait_count(PERIOD - 2);
        wr(2'd3, 8'h00);
        rd(2'd3, v);
        check(v == 2, "R11", "wrap set beats clear", v, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule